// File: doc/BRIEF.md
# Per-Byte Speculative Line Merger

This block assembles the cache line returned to a core whose speculative load has missed in its private first-level cache. Four cores run threads in a fixed logical order that starts at a rotating head core. Each core has a speculative write buffer, and the shared second-level cache holds committed data. All of these are consulted at once. The merger builds the returned 32-byte line one byte at a time. Each byte comes from the closest buffer at or before the requester in logical order that has written that byte. A byte that no such buffer has written comes from the second-level cache.

The caller presents a request along with the requester's core number, the head core number, and one snapshot from every buffer: a hit flag, a byte-write mask and the line data. It also presents the second-level line. One cycle later the merged line is delivered with a valid flag. A tag for each byte tells which source supplied it.

Top module: `spec_fwd_merge`

## Requirements
- R1: While reset is held and after it is released, rspValid is 0, rspData is all zeros and every byte tag reads 4 (the second-level cache code).
- R2: rspValid is 1 in the cycle after a cycle with reqValid high, and 0 in the cycle after a cycle with reqValid low.
- R3: Each byte is selected on its own, so bytes of one returned line may come from different sources.
- R4: For each byte the priority order is the requester's own buffer first, then the core one step earlier in logical order, and so on back to the head core. The second-level line comes last.
- R5: A buffer whose core is logically later than the requester never supplies a byte, whatever its hit flag and mask.
- R6: Logical position is (core - headCore) mod 4. A core is earlier than or equal to the requester when its position is not greater than the requester's position, and the order wraps around past core 3 to core 0.
- R7: A buffer supplies byte i only when its hit flag is 1 and bit i of its mask is 1.
- R8: A byte that no eligible buffer has written takes byte i of l2Data.
- R9: Byte i of a line occupies data bits [8i+7:8i] and tag bits [3i+2:3i]. The tag holds the core number 0..3 of the supplying buffer, or 4 for the second-level cache.
- R10: In a cycle after a cycle with reqValid low, rspData and rspSrc keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Merge request this cycle |
| reqCore | input | 2 | Core number of the requester |
| headCore | input | 2 | Core number of the non-speculative head |
| bufHit | input | 4 | Bit c: buffer of core c holds the line |
| bufMask | input | 128 | Bit c*32+i: buffer c has written byte i |
| bufData | input | 1024 | Bits (c*32+i)*8 +: 8: byte i of buffer c |
| l2Data | input | 256 | Second-level cache line |
| rspValid | output | 1 | Merged line valid |
| rspData | output | 256 | Merged line |
| rspSrc | output | 96 | Per-byte 3-bit source tag |

## Verification
The assertions compare each registered byte and its tag with the inputs sampled one edge earlier. They therefore assume that the buffer, mask, hit, core and head inputs are stable across the capturing edge and do not change before it. The bench changes every input only on the falling edge, so each capture sees one consistent snapshot. The head and requester numbers are always in the range 0..3, which the 2-bit ports enforce. The random phase draws every hit, mask and data bit independently, and it also covers wrap-around orders where the head is numerically above the requester.

// File: rtl/spec_fwd_pkg.sv
package spec_fwd_pkg;
  parameter int NUM_CORES  = 4;
  parameter int LINE_BYTES = 32;
  parameter int BYTE_W     = 8;

  localparam int CORE_W  = $clog2(NUM_CORES);
  localparam int SRC_W   = $clog2(NUM_CORES + 1);
  localparam int LINE_W  = LINE_BYTES * BYTE_W;
  localparam int MASK_W  = NUM_CORES * LINE_BYTES;
  localparam int BUF_W   = NUM_CORES * LINE_W;
  localparam int TAG_W   = LINE_BYTES * SRC_W;
  localparam logic [SRC_W-1:0] SRC_L2 = SRC_W'(NUM_CORES);

  // Strobes from control to datapath: rank k is the k-th closest eligible writer
  typedef struct packed {
    logic                              capture;
    logic [NUM_CORES-1:0]              rankEn;
    logic [NUM_CORES-1:0][CORE_W-1:0]  rankCore;
  } fwd_strobe_t;
endpackage

// File: rtl/spec_fwd_ctrl.sv
module spec_fwd_ctrl
  import spec_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [CORE_W-1:0] headCore,
  output fwd_strobe_t       strobe,
  output logic              rspValid
);
  logic [CORE_W-1:0] reqDist;

  // Position of requester relative to head; power-of-two core count wraps naturally
  assign reqDist = reqCore - headCore;

  always_comb begin
    strobe.capture = reqValid;
    for (int k = 0; k < NUM_CORES; k++) begin
      strobe.rankCore[k] = reqCore - CORE_W'(k);
      strobe.rankEn[k]   = (k <= int'(reqDist));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rspValid <= 1'b0;
    else        rspValid <= reqValid;
  end

  // R2: a response only ever follows a request
  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> $past(reqValid));
endmodule

// File: rtl/spec_fwd_datapath.sv
module spec_fwd_datapath
  import spec_fwd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  fwd_strobe_t        strobe,
  input  logic [NUM_CORES-1:0] bufHit,
  input  logic [MASK_W-1:0]  bufMask,
  input  logic [BUF_W-1:0]   bufData,
  input  logic [LINE_W-1:0]  l2Data,
  output logic [LINE_W-1:0]  rspData,
  output logic [TAG_W-1:0]   rspSrc
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] pickByte;
    logic [SRC_W-1:0]  pickSrc;

    // Per-byte priority encoder: scan farthest rank first so the nearest wins
    always_comb begin
      pickByte = l2Data[b*BYTE_W +: BYTE_W];
      pickSrc  = SRC_L2;
      for (int k = NUM_CORES - 1; k >= 0; k--) begin
        logic [CORE_W-1:0] c;
        c = strobe.rankCore[k];
        if (strobe.rankEn[k] && bufHit[c] && bufMask[int'(c)*LINE_BYTES + b]) begin
          pickByte = bufData[(int'(c)*LINE_BYTES + b)*BYTE_W +: BYTE_W];
          pickSrc  = SRC_W'(c);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rspData[b*BYTE_W +: BYTE_W] <= '0;
        rspSrc[b*SRC_W +: SRC_W]    <= SRC_L2;
      end else if (strobe.capture) begin
        rspData[b*BYTE_W +: BYTE_W] <= pickByte;
        rspSrc[b*SRC_W +: SRC_W]    <= pickSrc;
      end
    end
  end
endmodule

// File: rtl/spec_fwd_merge.sv
module spec_fwd_merge
  import spec_fwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [CORE_W-1:0]    headCore,
  input  logic [NUM_CORES-1:0] bufHit,
  input  logic [MASK_W-1:0]    bufMask,
  input  logic [BUF_W-1:0]     bufData,
  input  logic [LINE_W-1:0]    l2Data,
  output logic                 rspValid,
  output logic [LINE_W-1:0]    rspData,
  output logic [TAG_W-1:0]     rspSrc
);
  fwd_strobe_t strobe;

  spec_fwd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqCore(reqCore),
    .headCore(headCore), .strobe(strobe), .rspValid(rspValid)
  );

  spec_fwd_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .bufHit(bufHit),
    .bufMask(bufMask), .bufData(bufData), .l2Data(l2Data),
    .rspData(rspData), .rspSrc(rspSrc)
  );

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_chk_byte
    // R8: a byte tagged as second-level data equals the second-level byte at request time
    p_l2_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rspValid && rspSrc[b*SRC_W +: SRC_W] == SRC_L2)
        |-> rspData[b*BYTE_W +: BYTE_W] == $past(l2Data[b*BYTE_W +: BYTE_W]));
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk_core
      // R7: a buffer-sourced byte came from a hit buffer with its mask bit set
      p_hit_and_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rspValid && rspSrc[b*SRC_W +: SRC_W] == SRC_W'(c))
          |-> ($past(bufHit[c]) && $past(bufMask[c*LINE_BYTES + b]) &&
               rspData[b*BYTE_W +: BYTE_W] ==
                 $past(bufData[(c*LINE_BYTES + b)*BYTE_W +: BYTE_W])));
      // R5: the supplying core is never logically later than the requester
      p_no_later_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rspValid && rspSrc[b*SRC_W +: SRC_W] == SRC_W'(c))
          |-> (CORE_W'(c) - $past(headCore)) <= ($past(reqCore) - $past(headCore)));
    end
  end
endmodule

// File: tb/spec_fwd_merge_tb.sv
module spec_fwd_merge_tb;
  import spec_fwd_pkg::*;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 reqValid;
  logic [CORE_W-1:0]    reqCore, headCore;
  logic [NUM_CORES-1:0] bufHit;
  logic [MASK_W-1:0]    bufMask;
  logic [BUF_W-1:0]     bufData;
  logic [LINE_W-1:0]    l2Data;
  logic                 rspValid;
  logic [LINE_W-1:0]    rspData;
  logic [TAG_W-1:0]     rspSrc;

  logic                 expValid;
  logic [LINE_W-1:0]    expData;
  logic [TAG_W-1:0]     expSrc;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spec_fwd_merge u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqCore(reqCore),
    .headCore(headCore), .bufHit(bufHit), .bufMask(bufMask), .bufData(bufData),
    .l2Data(l2Data), .rspValid(rspValid), .rspData(rspData), .rspSrc(rspSrc)
  );

  task automatic randomData();
    for (int i = 0; i < BUF_W / 32; i++) bufData[i*32 +: 32] = $urandom;
    for (int i = 0; i < LINE_W / 32; i++) l2Data[i*32 +: 32] = $urandom;
  endtask

  // Reference: walk logical positions from requester back to head
  task automatic modelUpdate();
    int dr;
    dr = (int'(reqCore) - int'(headCore) + NUM_CORES) % NUM_CORES;
    expValid = reqValid;
    if (reqValid) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        bit found;
        int src;
        found = 0;
        src = NUM_CORES;
        for (int d = dr; d >= 0; d--) begin
          int c;
          c = (int'(headCore) + d) % NUM_CORES;
          if (!found && bufHit[c] && bufMask[c*LINE_BYTES + b]) begin
            found = 1;
            src = c;
          end
        end
        expSrc[b*SRC_W +: SRC_W] = SRC_W'(src);
        expData[b*BYTE_W +: BYTE_W] = found ? bufData[(src*LINE_BYTES + b)*BYTE_W +: BYTE_W]
                                            : l2Data[b*BYTE_W +: BYTE_W];
      end
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (rspValid !== expValid) begin
      failures++;
      $display("FAIL R2 (%s) rspValid actual %b expected %b", tag, rspValid, expValid);
    end
    checks++;
    if (rspData !== expData) begin
      failures++;
      $display("FAIL %s rspData actual %h expected %h", tag, rspData, expData);
    end
    checks++;
    if (rspSrc !== expSrc) begin
      failures++;
      $display("FAIL R9 (%s) rspSrc actual %h expected %h", tag, rspSrc, expSrc);
    end
  endtask

  // Inputs are already driven; the edge captures them, the next falling edge checks
  task automatic step(string tag);
    modelUpdate();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic setReq(input logic [CORE_W-1:0] rq, input logic [CORE_W-1:0] hd);
    reqValid = 1'b1;
    reqCore = rq;
    headCore = hd;
  endtask

  task automatic setMask(input int c, input logic [LINE_BYTES-1:0] m);
    bufMask[c*LINE_BYTES +: LINE_BYTES] = m;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reqValid = 1'b0;
    reqCore = '0;
    headCore = '0;
    bufHit = '0;
    bufMask = '0;
    randomData();
    expValid = 1'b0;
    expData = '0;
    for (int b = 0; b < LINE_BYTES; b++) expSrc[b*SRC_W +: SRC_W] = SRC_L2;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R4: all buffers full, requester at position 3 takes every byte
    setReq(2'd3, 2'd0); bufHit = 4'hF;
    for (int c = 0; c < 4; c++) setMask(c, '1);
    randomData(); step("R4 own buffer first");

    // R3 R4: interleaved masks so neighbouring bytes come from different cores
    setReq(2'd3, 2'd0); bufHit = 4'hF;
    setMask(3, 32'h5555_5555); setMask(2, 32'h0F0F_0F0F);
    setMask(1, 32'h0000_FFFF); setMask(0, 32'h0);
    randomData(); step("R3 per-byte mixing");

    // R5: later cores 2,3 fully written, must be ignored
    setReq(2'd1, 2'd0); bufHit = 4'hD;
    setMask(3, '1); setMask(2, '1); setMask(1, '1); setMask(0, 32'h0000_FFFF);
    randomData(); step("R5 later cores excluded");

    // R6: head 2 requester 0 -> chain 0,3,2; core 1 is later
    setReq(2'd0, 2'd2); bufHit = 4'hF;
    setMask(0, 32'h0000_00FF); setMask(3, 32'h0000_FF00);
    setMask(2, 32'h00FF_0000); setMask(1, '1);
    randomData(); step("R6 wraparound order");

    // R7: masks set but no hits -> every byte from L2
    setReq(2'd3, 2'd0); bufHit = 4'h0;
    for (int c = 0; c < 4; c++) setMask(c, '1);
    randomData(); step("R7 hit required");

    // R7 R8: hit but empty mask on the head requester
    setReq(2'd2, 2'd2); bufHit = 4'hF;
    setMask(2, 32'h0); setMask(3, '1); setMask(0, '1); setMask(1, '1);
    randomData(); step("R8 fallback to L2");

    // R10: no request, inputs change, outputs hold
    reqValid = 1'b0; bufHit = 4'hF; randomData();
    step("R10 hold without request");
    headCore = 2'd1; reqCore = 2'd3; randomData();
    step("R10 hold second cycle");

    // Random back-to-back traffic across all orders
    for (int n = 0; n < 400; n++) begin
      reqValid = ($urandom % 4) != 0;
      reqCore = CORE_W'($urandom);
      headCore = CORE_W'($urandom);
      bufHit = NUM_CORES'($urandom);
      for (int c = 0; c < 4; c++) setMask(c, $urandom);
      randomData();
      step("R4 random traffic");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule